// File: doc/BRIEF.md
# Interrupt Aggregation Controller

The block collects single-cycle event strobes from a USB side and a DMA side into two sticky status registers. Each register has its own per-bit enable register. Firmware sees the status bits through a read port and clears them by writing ones through a byte-lane write port. One interrupt pin is driven from the OR of all pending bits that are enabled. That OR is gated by a global enable bit, and the pin has a selectable active polarity and a selectable level or pulse mode. An event is always recorded, whether or not it is enabled.

The three lowest USB status bits come from endpoint pipes: control, IN and OUT. Each pipe reports ACK and NAK strobes, and a 2-bit mode field per pipe sets which handshakes produce a status event. The remaining USB status bits take general USB events directly. Once the pin is asserted, it stays asserted until the pending, enabled bits are cleared, even if firmware clears the global enable first.

Top module: `irq_aggregator`

## Requirements
- R1: After reset all registers read 0, and `irq_o` is 1: the reset state is active-low polarity, level mode and global enable off.
- R2: Status bits latch their events. USB status bits 0, 1 and 2 take the control, IN and OUT pipe events, and bits 3 and up take `usb_evt[0]` and up. DMA status bit i takes `dma_evt[i]`. Events latch whatever the enable and global settings are.
- R3: Status registers are write-1-to-clear. Only the bytes whose `wr_be` bit is set are affected. A new event arriving in the same cycle as its clear leaves the bit set.
- R4: A status bit contributes to the pin only while the matching bit in its enable register is set.
- R5: While global enable (mode register bit 0) is 0, the pin does not assert. When global enable goes to 1 with an enabled bit pending, the pin asserts one clock after the write takes effect.
- R6: Clearing global enable while the pin is asserted does not release it.
- R7: In level mode, the pin becomes active on the second clock edge after the event strobe. It becomes inactive on the clock edge after the write that clears the last enabled pending bit.
- R8: In pulse mode (configuration bit 1 = 1), each 0-to-1 change of the gated OR produces exactly PULSE_CYC clock cycles of the active level. Outside those cycles the pin is inactive.
- R9: Configuration bit 0 selects the active level, where 1 means active high. A change appears on the clock edge that writes it. A pulse already in progress keeps its full length.
- R10: The pipe mode fields sit at configuration bits [3:2] (control), [5:4] (IN) and [7:6] (OUT). Mode 00 raises an event on ACK or NAK. Mode 01 raises one on ACK only. Mode 10 raises one on ACK or on the first NAK. Mode 11 behaves as ACK only.
- R11: A pipe remembers a NAK until it next sees an ACK. In mode 10, further NAKs raise nothing until that ACK arrives.
- R12: `rd_data` returns, zero-extended, the register at `rd_addr`: 0 USB status, 1 USB enable, 2 DMA status, 3 DMA enable, 4 configuration, 5 mode. Any other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| usb_evt | input | USB_W-3 | General USB event strobes |
| dma_evt | input | DMA_W | DMA event strobes |
| pipe_ack | input | 3 | ACK strobes: control, IN, OUT |
| pipe_nak | input | 3 | NAK strobes: control, IN, OUT |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_be | input | 4 | Byte-lane enables |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 32 | Read data (combinational) |
| irq_o | output | 1 | Interrupt pin |

## Verification
A status bit becomes readable on the clock edge that samples its strobe. The pin follows one edge later, and it releases on the edge after the clearing write. A pulse occupies exactly PULSE_CYC cycles starting at that second edge. The bench drives inputs 2 ns after each rising edge. A behavioural model advances on each rising edge, and the pin and read data are compared with it at every falling edge. Directed checks sample 2 ns after the edge at which the expected value is due.

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
  parameter int USB_W     = 8,
  parameter int DMA_W     = 32,
  parameter int PULSE_CYC = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [USB_W-4:0]   usb_evt,
  input  logic [DMA_W-1:0]   dma_evt,
  input  logic [2:0]         pipe_ack,
  input  logic [2:0]         pipe_nak,
  input  logic               wr_en,
  input  logic [2:0]         wr_addr,
  input  logic [3:0]         wr_be,
  input  logic [31:0]        wr_data,
  input  logic [2:0]         rd_addr,
  output logic [31:0]        rd_data,
  output logic               irq_o
);
  localparam int CW = $clog2(PULSE_CYC + 1);

  logic [USB_W-1:0] ust, uen;
  logic [DMA_W-1:0] dst, den;
  logic [7:0]       cfg;
  logic             gen;
  logic [2:0]       nak_seen, pipe_evt;
  logic             act;
  logic [CW-1:0]    cnt;

  wire [31:0] bmask = {{8{wr_be[3]}}, {8{wr_be[2]}}, {8{wr_be[1]}}, {8{wr_be[0]}}};
  wire [31:0] wmask = wr_data & bmask;
  wire wr_ust = wr_en && wr_addr == 3'd0;
  wire wr_uen = wr_en && wr_addr == 3'd1;
  wire wr_dst = wr_en && wr_addr == 3'd2;
  wire wr_den = wr_en && wr_addr == 3'd3;
  wire wr_cfg = wr_en && wr_addr == 3'd4;
  wire wr_mod = wr_en && wr_addr == 3'd5;

  for (genvar p = 0; p < 3; p++) begin : g_pipe
    wire [1:0] md = cfg[2+2*p +: 2];
    assign pipe_evt[p] = pipe_ack[p] |
                         (pipe_nak[p] & ((md == 2'b00) | (md == 2'b10 && !nak_seen[p])));
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)              nak_seen[p] <= 1'b0;
      else if (pipe_ack[p])    nak_seen[p] <= 1'b0;
      else if (pipe_nak[p])    nak_seen[p] <= 1'b1;
  end

  wire [USB_W-1:0] usb_set = {usb_evt, pipe_evt};
  wire any = |(ust & uen) | |(dst & den);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ust <= '0; uen <= '0; dst <= '0; den <= '0;
      cfg <= '0; gen <= 1'b0; act <= 1'b0; cnt <= '0;
    end else begin
      ust <= (ust & ~(wr_ust ? wmask[USB_W-1:0] : '0)) | usb_set;
      dst <= (dst & ~(wr_dst ? wmask[DMA_W-1:0] : '0)) | dma_evt;
      if (wr_uen) uen <= (uen & ~bmask[USB_W-1:0]) | wmask[USB_W-1:0];
      if (wr_den) den <= (den & ~bmask[DMA_W-1:0]) | wmask[DMA_W-1:0];
      if (wr_cfg) cfg <= (cfg & ~bmask[7:0]) | wmask[7:0];
      if (wr_mod && wr_be[0]) gen <= wr_data[0];
      if (any && gen)  act <= 1'b1;
      else if (!any)   act <= 1'b0;
      if (!act && any && gen) cnt <= CW'(PULSE_CYC);
      else if (cnt != '0)     cnt <= cnt - 1'b1;
    end
  end

  wire phase = cfg[1] ? (cnt != '0) : act;
  assign irq_o = cfg[0] ? phase : ~phase;

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      3'd0: rd_data[USB_W-1:0] = ust;
      3'd1: rd_data[USB_W-1:0] = uen;
      3'd2: rd_data[DMA_W-1:0] = dst;
      3'd3: rd_data[DMA_W-1:0] = den;
      3'd4: rd_data[7:0]       = cfg;
      3'd5: rd_data[0]         = gen;
      default: rd_data = '0;
    endcase
  end

  assert_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_evt != '0) |=> ((dst & $past(dma_evt)) == $past(dma_evt)));
  assert_gate_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!act && !gen) |=> !act);
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (act && any) |=> act);
  assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !any |=> !act);
  assert_pulse_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |=> (cnt == $past(cnt) - 1'b1) || (cnt == CW'(PULSE_CYC)));
endmodule

// File: tb/test_irq_aggregator.sv
module test_irq_aggregator;
  localparam int USB_W = 8, DMA_W = 32, PULSE_CYC = 6;

  logic clk = 0, rst_n = 0;
  logic [USB_W-4:0] usb_evt = '0;
  logic [DMA_W-1:0] dma_evt = '0;
  logic [2:0] pipe_ack = '0, pipe_nak = '0;
  logic wr_en = 0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [3:0] wr_be = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic irq_o;

  irq_aggregator #(.USB_W(USB_W), .DMA_W(DMA_W), .PULSE_CYC(PULSE_CYC)) i_irq_aggregator (
    .clk(clk), .rst_n(rst_n), .usb_evt(usb_evt), .dma_evt(dma_evt),
    .pipe_ack(pipe_ack), .pipe_nak(pipe_nak), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_be(wr_be), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq_o(irq_o));

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;

  // behavioural reference
  logic [31:0] m_ust, m_uen, m_dst, m_den, m_cfg, m_mod;
  bit m_act; int m_cnt; bit m_nak [3];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ust = 0; m_uen = 0; m_dst = 0; m_den = 0; m_cfg = 0; m_mod = 0;
      m_act = 0; m_cnt = 0;
      for (int p = 0; p < 3; p++) m_nak[p] = 0;
    end else begin
      bit pend; logic [31:0] bm, clr; logic [31:0] uset;
      pend = ((m_ust & m_uen) | (m_dst & m_den)) != 0;
      if (!m_act && pend && m_mod[0]) m_cnt = PULSE_CYC;
      else if (m_cnt > 0) m_cnt--;
      if (pend && m_mod[0]) m_act = 1; else if (!pend) m_act = 0;
      uset = 32'(usb_evt) << 3;
      for (int p = 0; p < 3; p++) begin
        int md; md = (m_cfg >> (2 + 2*p)) & 3;
        if (pipe_ack[p] || (pipe_nak[p] && (md == 0 || (md == 2 && !m_nak[p])))) uset[p] = 1;
        if (pipe_ack[p]) m_nak[p] = 0; else if (pipe_nak[p]) m_nak[p] = 1;
      end
      bm = 0;
      for (int b = 0; b < 4; b++) if (wr_be[b]) bm |= 32'hFF << (8*b);
      clr = wr_data & bm;
      case (wr_en ? wr_addr : 3'd7)
        3'd0: m_ust &= ~clr;
        3'd1: m_uen = (m_uen & ~bm) | clr;
        3'd2: m_dst &= ~clr;
        3'd3: m_den = (m_den & ~bm) | clr;
        3'd4: m_cfg = (m_cfg & ~bm) | clr;
        3'd5: if (wr_be[0]) m_mod = {31'd0, wr_data[0]};
        default: ;
      endcase
      m_ust = (m_ust | uset) & 32'hFF;
      m_dst = m_dst | 32'(dma_evt);
      m_uen &= 32'hFF; m_cfg &= 32'hFF;
    end
  end

  function automatic logic [31:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return m_ust; 3'd1: return m_uen; 3'd2: return m_dst;
      3'd3: return m_den; 3'd4: return m_cfg; 3'd5: return m_mod;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act_v, input logic [31:0] exp_v);
    checks++;
    if (act_v !== exp_v) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act_v, exp_v, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    bit ph;
    ph = m_cfg[1] ? (m_cnt != 0) : m_act;
    chk("R7 model pin", {31'd0, irq_o}, {31'd0, m_cfg[0] ? ph : ~ph});
    chk("R12 model read", rd_data, m_read(rd_addr));
  end

  task automatic cyc();
    @(posedge clk); #2;
    usb_evt = '0; dma_evt = '0; pipe_ack = '0; pipe_nak = '0; wr_en = 0;
  endtask
  task automatic wr(input logic [2:0] a, input logic [3:0] be, input logic [31:0] d);
    wr_en = 1; wr_addr = a; wr_be = be; wr_data = d; cyc();
  endtask
  task automatic rd_chk(input string tag, input logic [2:0] a, input logic [31:0] e);
    rd_addr = a; #1; chk(tag, rd_data, e);
  endtask
  task automatic summary();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    int lows;
    repeat (3) @(posedge clk); #2; rst_n = 1;
    chk("R1 pin idle", {31'd0, irq_o}, 32'd1);
    rd_chk("R1 cfg zero", 3'd4, 0);
    rd_chk("R1 status zero", 3'd0, 0);

    usb_evt = 5'd1; cyc();
    rd_chk("R2 latch masked", 3'd0, 32'h08);
    cyc(); chk("R4 disabled bit", {31'd0, irq_o}, 32'd1);
    wr(3'd1, 4'h1, 32'h08); cyc();
    chk("R5 global off", {31'd0, irq_o}, 32'd1);
    wr(3'd5, 4'h1, 32'h1); cyc();
    chk("R5 global on asserts", {31'd0, irq_o}, 32'd0);
    wr(3'd5, 4'h1, 32'h0); cyc(); cyc();
    chk("R6 held after global off", {31'd0, irq_o}, 32'd0);
    wr(3'd0, 4'h1, 32'h08);
    rd_chk("R3 cleared", 3'd0, 0);
    cyc(); chk("R7 release", {31'd0, irq_o}, 32'd1);

    dma_evt = 32'h201; cyc();
    wr(3'd2, 4'b0010, 32'hFFFFFFFF);
    rd_chk("R3 byte lane", 3'd2, 32'h1);
    dma_evt = 32'h1; wr(3'd2, 4'hF, 32'hFFFFFFFF);
    rd_chk("R3 set wins", 3'd2, 32'h1);
    wr(3'd2, 4'hF, 32'hFFFFFFFF);
    rd_chk("R3 all clear", 3'd2, 0);

    wr(3'd4, 4'h1, 32'h2); wr(3'd5, 4'h1, 32'h1);
    usb_evt = 5'd1; cyc();
    lows = 0;
    for (int i = 0; i < 20; i++) begin cyc(); if (!irq_o) lows++; end
    chk("R8 pulse length", lows, PULSE_CYC);
    chk("R8 no repeat", {31'd0, irq_o}, 32'd1);
    wr(3'd0, 4'h1, 32'h08);

    wr(3'd4, 4'h1, 32'h1);
    chk("R9 polarity high idle", {31'd0, irq_o}, 32'd0);
    wr(3'd4, 4'h1, 32'h3);
    usb_evt = 5'd1; cyc(); cyc();
    chk("R9 pulse high", {31'd0, irq_o}, 32'd1);
    wr(3'd4, 4'h1, 32'h2);
    chk("R9 flip mid pulse", {31'd0, irq_o}, 32'd0);
    lows = 0;
    for (int i = 0; i < 15; i++) begin cyc(); if (!irq_o) lows++; end
    chk("R9 pulse finishes", lows, PULSE_CYC - 2);
    wr(3'd0, 4'h1, 32'h08);

    wr(3'd4, 4'h1, 32'h90);
    pipe_nak = 3'b111; cyc();
    rd_chk("R10 nak modes", 3'd0, 32'h5);
    wr(3'd0, 4'h1, 32'h7);
    pipe_nak = 3'b111; cyc();
    rd_chk("R11 second nak suppressed", 3'd0, 32'h1);
    wr(3'd0, 4'h1, 32'h7);
    pipe_ack = 3'b100; cyc(); wr(3'd0, 4'h1, 32'h7);
    pipe_nak = 3'b100; cyc();
    rd_chk("R11 rearm after ack", 3'd0, 32'h4);
    wr(3'd0, 4'h1, 32'h7);
    pipe_ack = 3'b010; cyc();
    rd_chk("R10 ack only", 3'd0, 32'h2);
    wr(3'd0, 4'h1, 32'h7);
    wr(3'd4, 4'h1, 32'hB0);
    pipe_nak = 3'b010; cyc();
    rd_chk("R10 reserved nak", 3'd0, 32'h0);
    pipe_ack = 3'b010; cyc();
    rd_chk("R10 reserved ack", 3'd0, 32'h2);

    wr(3'd3, 4'hF, 32'hA5A50F0F);
    rd_chk("R12 dma enable", 3'd3, 32'hA5A50F0F);
    rd_chk("R12 unused addr", 3'd6, 0);
    cyc(); cyc();
    summary();
  end
endmodule